// File: doc/BRIEF.md
# Row Hit Pattern Stimulus Generator

This block produces hit vectors that stand in for the discriminator outputs of one 960-pixel sensor row. It is meant to feed a zero-suppression stage with the patterns most likely to break it. Every emulated frame has two lines. Line 0 is presented in one cycle and line 1 in the cycle after it. Each frame is flagged by a start strobe on its first line and by a valid strobe on both lines.

A start pulse given while the block is idle latches a test mode and a frame count. The block then plays that many frames and raises a done flag. Three modes emit fixed corner-case sets: the two array edges, or the first boundaries between 64-column groups. Two modes walk a single hit across the row, one position per frame, in one of the two line slots. A frame count of zero selects a default length: 5000 frames for the fixed modes and 500 for the walking modes.

Top module: `linePatternGen`

## Requirements
- R1: After reset, lineValid, frameStart and done are 0 and hitVec is all zeros.
- R2: A start pulse with a valid mode, sampled while idle, makes the next cycle a line 0 cycle. A line 0 cycle has lineValid=1, lineIdx=0 and frameStart=1. The cycle after it is a line 1 cycle, with lineValid=1, lineIdx=0 changed to lineIdx=1, and frameStart=0. Frames follow one another with no gap.
- R3: Mode code 1 gives an all-zero line 0. Its line 1 has only bits 0 and 959 set.
- R4: Mode code 2 gives a line 0 with only bits 0 and 959 set. Its line 1 is all zeros.
- R5: Mode code 3 gives a line 0 with only bits 0, 63, 64, 127 and 128 set. Its line 1 is all zeros.
- R6: Mode code 4 gives a line 0 with a single hit at the position equal to the frame number, counted from 0. Its line 1 is all zeros.
- R7: Mode code 5 gives an all-zero line 0. Its line 1 has a single hit at the position equal to the frame number.
- R8: In the walking modes, the hit position returns to 0 after 959. Frame k uses position k mod 960.
- R9: Exactly frameCount frames are played. A frameCount of 0 plays 5000 frames in modes 1 to 3 and 500 frames in modes 4 and 5.
- R10: done rises in the first idle cycle after the last line 1. It holds until a start with a valid mode is accepted, and it is 0 while lines are emitted.
- R11: During a run, start, modeSel and frameCount have no effect. This holds also when start coincides with the final line 1 cycle.
- R12: hitVec is all zeros whenever lineValid is 0.
- R13: A start with mode code 0, 6 or 7 is ignored. The block stays idle and done keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Run request, sampled while idle |
| modeSel | input | 3 | Test mode code, 1 to 5 |
| frameCount | input | 16 | Frames to play; 0 selects the mode default |
| hitVec | output | 960 | Emulated discriminator hits for the current line |
| lineIdx | output | 1 | Line slot of the current cycle, 0 or 1 |
| frameStart | output | 1 | High on the line 0 cycle of each frame |
| lineValid | output | 1 | High on every emitted line |
| done | output | 1 | Run finished, held until the next accepted start |

## Verification
Two events can land in the same cycle: a fresh start request and the block's own end of run, when the final line 1 is leaving. The bench provokes this by holding start high during every line 1 cycle of a run, the last one included, while it also changes modeSel and frameCount mid-run. The result is judged correct when three things hold. The patterns stay those of the latched mode. The run stops after exactly the latched number of frames. The following cycle is idle with done set, not a new line 0.

// File: rtl/lpgPkg.sv
package lpgPkg;
  typedef enum logic [2:0] {
    MODE_NONE     = 3'd0,
    MODE_EDGE_L1  = 3'd1,
    MODE_EDGE_L0  = 3'd2,
    MODE_GROUP_L0 = 3'd3,
    MODE_WALK_L0  = 3'd4,
    MODE_WALK_L1  = 3'd5
  } testMode_e;

  typedef struct packed {
    logic load;
    logic advance;
    logic active;
    logic lineSel;
  } lpgStrobe_t;

  function automatic logic isWalk(testMode_e m);
    return (m == MODE_WALK_L0) || (m == MODE_WALK_L1);
  endfunction
endpackage

// File: rtl/lpgControl.sv
module lpgControl
  import lpgPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       modeOk,
  input  logic       lastFrame,
  output lpgStrobe_t strobe,
  output logic       frameStart,
  output logic       lineValid,
  output logic       lineIdx,
  output logic       done
);
  typedef enum logic [1:0] {ST_IDLE, ST_LINE0, ST_LINE1} state_e;
  state_e state;

  always_comb begin
    strobe.load    = (state == ST_IDLE) && start && modeOk;
    strobe.advance = (state == ST_LINE1) && !lastFrame;
    strobe.active  = (state != ST_IDLE);
    strobe.lineSel = (state == ST_LINE1);
    lineValid      = strobe.active;
    lineIdx        = strobe.lineSel;
    frameStart     = (state == ST_LINE0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (strobe.load) begin
          state <= ST_LINE0;
          done  <= 1'b0;
        end
        ST_LINE0: state <= ST_LINE1;
        ST_LINE1: if (lastFrame) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end else begin
          state <= ST_LINE0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_LINE_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    (lineValid && !lineIdx) |=> (lineValid && lineIdx)); // R2
  AST_FS_ON_LINE0: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> (lineValid && !lineIdx)); // R2
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !lineValid); // R10
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done); // R10
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (lineValid && start) |=> (lineValid || done)); // R11
endmodule

// File: rtl/lpgDatapath.sv
module lpgDatapath
  import lpgPkg::*;
#(
  parameter int WIDTH       = 960,
  parameter int GROUP       = 64,
  parameter int FCW         = 16,
  parameter int FIXED_FRAMES = 5000,
  parameter int WALK_FRAMES  = 500
) (
  input  logic             clk,
  input  logic             rstN,
  input  lpgStrobe_t       strobe,
  input  logic [2:0]       modeSel,
  input  logic [FCW-1:0]   frameCount,
  output logic             modeOk,
  output logic             lastFrame,
  output logic [WIDTH-1:0] hitVec
);
  localparam int POSW = $clog2(WIDTH);
  localparam logic [POSW-1:0] POS_LAST = POSW'(WIDTH - 1);
  localparam logic [FCW-1:0] FIXED_N = FCW'(FIXED_FRAMES);
  localparam logic [FCW-1:0] WALK_N  = FCW'(WALK_FRAMES);

  testMode_e       curMode;
  logic [FCW-1:0]  remain;
  logic [POSW-1:0] pos;
  logic [FCW-1:0]  loadCount;
  logic [WIDTH-1:0] pattern;
  testMode_e       reqMode;

  always_comb begin
    reqMode   = testMode_e'(modeSel);
    modeOk    = (modeSel >= 3'd1) && (modeSel <= 3'd5);
    lastFrame = (remain == '0);
    if (frameCount != '0) loadCount = frameCount;
    else if (isWalk(reqMode)) loadCount = WALK_N;
    else loadCount = FIXED_N;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curMode <= MODE_NONE;
      remain  <= '0;
      pos     <= '0;
    end else if (strobe.load) begin
      curMode <= reqMode;
      remain  <= loadCount - 1'b1;
      pos     <= '0;
    end else if (strobe.advance) begin
      remain  <= remain - 1'b1;
      pos     <= (pos == POS_LAST) ? '0 : pos + 1'b1;
    end
  end

  always_comb begin
    pattern = '0;
    unique case (curMode)
      MODE_EDGE_L1: if (strobe.lineSel) begin
        pattern[0]       = 1'b1;
        pattern[WIDTH-1] = 1'b1;
      end
      MODE_EDGE_L0: if (!strobe.lineSel) begin
        pattern[0]       = 1'b1;
        pattern[WIDTH-1] = 1'b1;
      end
      MODE_GROUP_L0: if (!strobe.lineSel) begin
        pattern[0]         = 1'b1;
        pattern[GROUP-1]   = 1'b1;
        pattern[GROUP]     = 1'b1;
        pattern[2*GROUP-1] = 1'b1;
        pattern[2*GROUP]   = 1'b1;
      end
      MODE_WALK_L0: if (!strobe.lineSel) pattern[pos] = 1'b1;
      MODE_WALK_L1: if (strobe.lineSel)  pattern[pos] = 1'b1;
      default: ;
    endcase
    hitVec = strobe.active ? pattern : '0;
  end

  AST_WALK_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.active && ((curMode == MODE_WALK_L0 && !strobe.lineSel) ||
                       (curMode == MODE_WALK_L1 && strobe.lineSel)))
      |-> ($countones(hitVec) == 1)); // R6
  AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    pos <= POS_LAST); // R8
  AST_POS_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && pos == POS_LAST) |=> (pos == '0)); // R8
  AST_MODE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.active |=> $stable(curMode)); // R11
endmodule

// File: rtl/linePatternGen.sv
module linePatternGen
  import lpgPkg::*;
#(
  parameter int WIDTH        = 960,
  parameter int GROUP        = 64,
  parameter int FCW          = 16,
  parameter int FIXED_FRAMES = 5000,
  parameter int WALK_FRAMES  = 500
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [2:0]       modeSel,
  input  logic [FCW-1:0]   frameCount,
  output logic [WIDTH-1:0] hitVec,
  output logic             lineIdx,
  output logic             frameStart,
  output logic             lineValid,
  output logic             done
);
  lpgStrobe_t strobe;
  logic modeOk;
  logic lastFrame;

  lpgControl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .modeOk(modeOk),
    .lastFrame(lastFrame), .strobe(strobe), .frameStart(frameStart),
    .lineValid(lineValid), .lineIdx(lineIdx), .done(done)
  );

  lpgDatapath #(
    .WIDTH(WIDTH), .GROUP(GROUP), .FCW(FCW),
    .FIXED_FRAMES(FIXED_FRAMES), .WALK_FRAMES(WALK_FRAMES)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .modeSel(modeSel),
    .frameCount(frameCount), .modeOk(modeOk), .lastFrame(lastFrame),
    .hitVec(hitVec)
  );

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !lineValid |-> (hitVec == '0)); // R12
endmodule

// File: tb/sim_linePatternGen.sv
module sim_linePatternGen;
  localparam int W = 960;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [2:0]   modeSel = 3'd0;
  logic [15:0]  frameCount = 16'd0;
  logic [W-1:0] hitVec;
  logic         lineIdx, frameStart, lineValid, done;

  int nTests = 0;
  int nFail  = 0;

  always #4 clk = ~clk;

  linePatternGen u0 (
    .clk(clk), .rstN(rstN), .start(start), .modeSel(modeSel),
    .frameCount(frameCount), .hitVec(hitVec), .lineIdx(lineIdx),
    .frameStart(frameStart), .lineValid(lineValid), .done(done)
  );

  function automatic logic [W-1:0] expVec(int mode, int frame, int line);
    logic [W-1:0] v = '0;
    int p = frame % W;
    case (mode)
      1: if (line == 1) begin v[0] = 1'b1; v[W-1] = 1'b1; end
      2: if (line == 0) begin v[0] = 1'b1; v[W-1] = 1'b1; end
      3: if (line == 0) begin
           v[0] = 1'b1; v[63] = 1'b1; v[64] = 1'b1; v[127] = 1'b1; v[128] = 1'b1;
         end
      4: if (line == 0) v[p] = 1'b1;
      5: if (line == 1) v[p] = 1'b1;
      default: ;
    endcase
    return v;
  endfunction

  task automatic checkFlag(string req, logic got, logic exp, string what);
    nTests++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
    end
  endtask

  task automatic tReset();
    checkFlag("R1", lineValid, 1'b0, "lineValid after reset");
    checkFlag("R1", frameStart, 1'b0, "frameStart after reset");
    checkFlag("R1", done, 1'b0, "done after reset");
    checkFlag("R12", hitVec == '0, 1'b1, "hitVec zero after reset");
  endtask

  task automatic runMode(int mode, int cnt, string req, bit disturb);
    int frames = (cnt != 0) ? cnt : ((mode >= 4) ? 500 : 5000);
    @(negedge clk);
    start = 1'b1; modeSel = 3'(mode); frameCount = 16'(cnt);
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin modeSel = 3'd1; frameCount = 16'd7; end
    for (int f = 0; f < frames; f++) begin
      for (int l = 0; l < 2; l++) begin
        logic [W-1:0] e;
        logic ok;
        if (!(f == 0 && l == 0)) @(negedge clk);
        e  = expVec(mode, f, l);
        ok = (hitVec === e) && lineValid && (lineIdx == l[0]) &&
             (frameStart == (l == 0)) && !done;
        nTests++;
        if (!ok) begin
          nFail++;
          $display("FAIL %s R2 mode %0d frame %0d line %0d: got valid=%0b idx=%0b fs=%0b done=%0b ones=%0d vec=%h expected idx=%0d ones=%0d vec=%h",
                   req, mode, f, l, lineValid, lineIdx, frameStart, done,
                   $countones(hitVec), hitVec, l, $countones(e), e);
        end
        if (disturb) start = (l == 1);
      end
    end
    @(negedge clk);
    start = 1'b0;
    checkFlag("R9", lineValid, 1'b0, "idle after last frame");
    checkFlag("R10", done, 1'b1, "done after last frame");
    checkFlag("R12", hitVec == '0, 1'b1, "hitVec zero when idle");
  endtask

  task automatic tDoneHold();
    repeat (5) @(negedge clk);
    checkFlag("R10", done, 1'b1, "done held while idle");
    checkFlag("R11", lineValid, 1'b0, "no restart from start on last line");
  endtask

  task automatic tInvalid(int code);
    @(negedge clk);
    start = 1'b1; modeSel = 3'(code); frameCount = 16'd3;
    @(negedge clk);
    start = 1'b0;
    checkFlag("R13", lineValid, 1'b0, "invalid mode not started");
    checkFlag("R13", done, 1'b1, "done kept on invalid mode");
    @(negedge clk);
    checkFlag("R13", lineValid, 1'b0, "still idle after invalid mode");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    runMode(1, 3, "R3", 1'b0);
    runMode(2, 3, "R4", 1'b0);
    runMode(3, 2, "R5", 1'b0);
    tInvalid(0);
    tInvalid(6);
    tInvalid(7);
    runMode(4, 0, "R6 R9", 1'b0);
    runMode(5, 962, "R7 R8", 1'b0);
    runMode(2, 2, "R11", 1'b1);
    tDoneHold();
    runMode(1, 0, "R9", 1'b0);
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule